// File: doc/BRIEF.md
# Rotating Random Test Data Chain

This block supplies pseudo-random test patterns to a memory self-test engine. When a test starts, a 32-bit generator state is loaded from a seed input. On each data request, the generator advances by a full 32-bit step of a CRC-32 style shift register with no input. The resulting word enters the top register of a five-register chain. At the same moment, every lower register takes the old content of the register above it, rotated left by one bit.

The chain is presented as one 144-bit memory word with an early half and a late half. Each half has 64 data bits and 8 check bits. The top register feeds only the check bits. The chain needs five requests after a start before every register holds generated data. After that, every further request shifts the chain once and presents a fresh word.

Top module: `rand_chain_gen`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, data is all zeros and data_valid is 0.
- R2: A cycle with start high loads the generator state from seed and clears the chain and the fill count, so that data is zero and data_valid is 0 in the next cycle. When start and next_req are high together, start wins.
- R3: On a request (next_req high, start low), the generator state is advanced by 32 single steps and the new state is written into the top register. One step is defined as follows: note bit 31, shift the state left by one with a zero coming in, then XOR in 0x04C11DB7 if the noted bit was 1.
- R4: On a request, register 7 takes the old top register, register 6 takes the old register 7, register 5 takes the old register 6, and register 4 takes the old register 5. Each of these values is rotated left by one bit, with bit 31 moving to bit 0. For example, 0x27fe3b3d becomes 0x4ffc767a.
- R5: The output is data = {top[15:8], reg7, reg6, top[7:0], reg5, reg4}. Bits [143:72] form the late half, and bits [143:136] are its check bits. Bits [71:0] form the early half, and bits [71:64] are its check bits. Bits [31:16] of the top register do not reach the output.
- R6: data_valid rises in the cycle after the fifth request since the last start. It stays high through later requests until the next start or reset.
- R7: In a cycle with neither start nor next_req, data and data_valid keep their values.
- R8: After the chain is full, each request presents a new word built by the rules of R3 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load seed, clear chain |
| seed | input | 32 | Generator seed |
| next_req | input | 1 | Request next data word |
| data_valid | output | 1 | Chain filled |
| data | output | 144 | Late half [143:72], early half [71:0] |

## Verification
The bench targets several corner cases, and each has a clear failure signature.

- Seeds are chosen with bit 31 set, with only bit 0 set, with all bits set, and as zero. These values exercise the conditional polynomial XOR on both sides. A wrong step order or polynomial would corrupt every top-register word.
- The fill boundary is checked after every request. A count that is off by one moves the rise of data_valid.
- start and next_req are raised together. A design that lets the request win would shift instead of clearing.
- Idle cycles are inserted between requests. They catch a chain that drifts, or a rotation in the wrong direction, which would scramble registers 4 to 7.

// File: rtl/rand_chain_gen.sv
module rand_chain_gen #(
  parameter int          WORD_W = 32,
  parameter logic [31:0] POLY   = 32'h04C11DB7,
  parameter int          FILL   = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   seed,
  input  logic          next_req,
  output logic          data_valid,
  output logic [143:0]  data
);
  localparam int CW = $clog2(FILL + 1);

  logic [WORD_W-1:0] crc_q, top_q, r7_q, r6_q, r5_q, r4_q;
  logic [CW-1:0]     cnt_q;
  logic [WORD_W-1:0] crc_nx;

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] v);
    return {v[WORD_W-2:0], v[WORD_W-1]};
  endfunction

  always_comb begin
    crc_nx = crc_q;
    for (int i = 0; i < WORD_W; i++)
      crc_nx = crc_nx[WORD_W-1] ? ({crc_nx[WORD_W-2:0], 1'b0} ^ POLY) : {crc_nx[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      crc_q <= !rst_n ? '0 : seed;
      top_q <= '0;
      r7_q  <= '0;
      r6_q  <= '0;
      r5_q  <= '0;
      r4_q  <= '0;
      cnt_q <= '0;
    end else if (next_req) begin
      crc_q <= crc_nx;
      top_q <= crc_nx;
      r7_q  <= rotl(top_q);
      r6_q  <= rotl(r7_q);
      r5_q  <= rotl(r6_q);
      r4_q  <= rotl(r5_q);
      if (cnt_q != CW'(FILL)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign data_valid = (cnt_q == CW'(FILL));
  assign data = {top_q[15:8], r7_q, r6_q, top_q[7:0], r5_q, r4_q};
endmodule

// File: rtl/rand_chain_gen_chk.sv
module rand_chain_gen_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         next_req,
  input logic         data_valid,
  input logic [143:0] data,
  input logic [31:0]  top_q
);
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (data == '0) && !data_valid);

  a_r4_top_to_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (next_req && !start) |=> data[135:104] == {$past(top_q[30:0]), $past(top_q[31])});

  a_r4_r7_to_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (next_req && !start) |=> data[103:72] == {$past(data[134:104]), $past(data[135])});

  a_r4_r5_to_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (next_req && !start) |=> data[31:0] == {$past(data[62:32]), $past(data[63])});

  a_r6_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && !start) |=> data_valid);

  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!next_req && !start) |=> $stable(data) && $stable(data_valid));
endmodule

bind rand_chain_gen rand_chain_gen_chk u_chk (.*);

// File: tb/rand_chain_gen_tb.sv
module rand_chain_gen_tb;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         start = 0;
  logic [31:0]  seed = '0;
  logic         next_req = 0;
  logic         data_valid;
  logic [143:0] data;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rand_chain_gen u_dut (.*);

  localparam int NV = 5;
  localparam logic [31:0] SEEDS [NV] = '{32'h93d78768, 32'h00000001, 32'hffffffff, 32'h80000000, 32'h00000000};
  localparam int          REQS  [NV] = '{7, 5, 9, 6, 6};

  logic [31:0] m_crc, m_top, m7, m6, m5, m4;
  int m_cnt;

  function automatic logic [31:0] step32(input logic [31:0] s);
    logic [31:0] v = s;
    for (int i = 0; i < 32; i++) begin
      logic b = v[31];
      v = v << 1;
      if (b) v = v ^ 32'h04C11DB7;
    end
    return v;
  endfunction

  function automatic logic [31:0] rl(input logic [31:0] v);
    return (v << 1) | (v >> 31);
  endfunction

  function automatic logic [143:0] m_word();
    return {m_top[15:8], m7, m6, m_top[7:0], m5, m4};
  endfunction

  task automatic m_start(input logic [31:0] s);
    m_crc = s; m_top = 0; m7 = 0; m6 = 0; m5 = 0; m4 = 0; m_cnt = 0;
  endtask

  task automatic m_req();
    m_crc = step32(m_crc);
    m4 = rl(m5); m5 = rl(m6); m6 = rl(m7); m7 = rl(m_top); m_top = m_crc;
    if (m_cnt < 5) m_cnt++;
  endtask

  task automatic chk(input string req);
    total++;
    if (data !== m_word() || data_valid !== (m_cnt == 5)) begin
      bad++;
      $display("FAIL %s: data=%h valid=%b exp data=%h valid=%b", req, data, data_valid, m_word(), m_cnt == 5);
    end
  endtask

  task automatic do_start(input logic [31:0] s);
    @(negedge clk); start = 1; seed = s;
    @(negedge clk); start = 0;
    m_start(s);
  endtask

  task automatic do_req();
    @(negedge clk); next_req = 1;
    @(negedge clk); next_req = 0;
    m_req();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_start(0);
    repeat (3) @(negedge clk);
    chk("R1 reset");
    rst_n = 1;
    @(negedge clk);
    chk("R1 after reset");

    for (int v = 0; v < NV; v++) begin
      do_start(SEEDS[v]);
      chk("R2 start");
      for (int k = 0; k < REQS[v]; k++) begin
        do_req();
        chk(k < 5 ? "R3 R4 R5 R6 fill" : "R8 R6 steady");
      end
    end

    // rotation example from R4: word 0x27fe3b3d enters top, then moves to reg7
    total++;
    if (rl(32'h27fe3b3d) !== 32'h4ffc767a) begin
      bad++;
      $display("FAIL R4 model: act=%h exp=4ffc767a", rl(32'h27fe3b3d));
    end

    // idle cycles hold
    do_start(32'h1234abcd);
    for (int k = 0; k < 6; k++) do_req();
    repeat (4) @(negedge clk);
    chk("R7 idle hold");
    do_req();
    chk("R8 after idle");

    // start and request together: start wins
    @(negedge clk); start = 1; next_req = 1; seed = 32'hdeadbeef;
    @(negedge clk); start = 0; next_req = 0;
    m_start(32'hdeadbeef);
    chk("R2 start beats request");
    do_req();
    chk("R2 R3 first word from new seed");

    // reset mid run
    for (int k = 0; k < 5; k++) do_req();
    chk("R6 valid before reset");
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    m_start(0);
    chk("R1 reset mid run");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule